// File: doc/BRIEF.md
# Error Status Register Block

This block holds the error reporting state for uncorrectable and correctable errors behind a 32-bit register port. Single-cycle event pulses from the surrounding logic set sticky status bits, and software clears them by writing ones. Each class has a mask register. The uncorrectable class also has a severity register. An interrupt output per class stays high while any status bit is set and not masked.

A read-only capability/control word carries a fixed resource value and a six-bit first-error pointer. The pointer records which uncorrectable error arrived first after the status register was last empty. Reads return data one cycle after the request. Writes complete in the cycle they are presented.

Top module: `errs_regs`

## Requirements
- R1: After reset the registers read as follows: uncorrectable status 0, uncorrectable mask 0x1CFFF, uncorrectable severity 0x1CFFF, correctable status 0, correctable mask 0x7F, capability word 0x200. Both interrupts are low and `rd_valid` is low.
- R2: Uncorrectable registers implement only the bits in 0x1CFFF. Bits 12, 13 and 17 to 31 read zero and ignore writes. Correctable registers implement only bits [6:0].
- R3: The register offsets are 0x00 uncorrectable status, 0x04 uncorrectable mask, 0x08 uncorrectable severity, 0x0C correctable status, 0x10 correctable mask and 0x14 capability word. A write to a mask or severity register stores the write data ANDed with that register's implemented bits.
- R4: A write to a status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A high `unc_evt` or `cor_evt` bit in a cycle sets the matching implemented status bit at that clock edge. Event bits at unimplemented positions are ignored. If a set and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: `unc_irq` is high exactly while (uncorrectable status AND NOT uncorrectable mask) is nonzero. `cor_irq` follows the same rule for the correctable class.
- R7: The capability word is read-only. Bits [31:6] always read 0x200 >> 6 in place, and writes to it have no effect.
- R8: Capability bits [5:0] form the first-error pointer. The pointer loads in a cycle only if the uncorrectable status is zero and at least one unmasked uncorrectable event arrives. It then takes the lowest index among those unmasked events. Otherwise it holds.
- R9: Only accesses with `req_addr[1:0]` equal to 0 take effect. Misaligned writes are ignored and misaligned reads return 0. Aligned reads of undefined offsets return 0. Read data and a high `rd_valid` appear in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| unc_evt | input | 32 | Uncorrectable error event pulses, one per bit |
| cor_evt | input | 32 | Correctable error event pulses, one per bit |
| unc_irq | output | 1 | Unmasked uncorrectable error pending |
| cor_irq | output | 1 | Unmasked correctable error pending |

## Verification
Register writes are exercised with all-ones, reserved-only, checkerboard and sparse patterns. These show whether the implemented-bit masks are applied per register, and whether the capability word and undefined offsets ignore data. Event patterns mix implemented and reserved positions, and mix masked and unmasked bits. This separates status setting from interrupt gating and from the lowest-index choice of the first-error pointer. Clear patterns combine W1C writes with simultaneous events and with misaligned addresses, which shows set priority and the alignment filter.

// File: rtl/errs_pkg.sv
package errs_pkg;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int IW = AW - 2;

    // Word index of each register (byte address >> 2)
    localparam logic [IW-1:0] W_UNC_STAT = IW'(0);
    localparam logic [IW-1:0] W_UNC_MASK = IW'(1);
    localparam logic [IW-1:0] W_UNC_SEV  = IW'(2);
    localparam logic [IW-1:0] W_COR_STAT = IW'(3);
    localparam logic [IW-1:0] W_COR_MASK = IW'(4);
    localparam logic [IW-1:0] W_CAP      = IW'(5);

    typedef struct packed {
        logic          rd_valid;
        logic [DW-1:0] rd_data;
        logic [DW-1:0] sev;
    } top_state_t;
endpackage

// File: rtl/errs_status_bank.sv
module errs_status_bank #(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] VALID    = '1,
    parameter logic [DW-1:0] MASK_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_i,
    input  logic          wr_stat_i,
    input  logic          wr_mask_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] mask_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] status;
        logic [DW-1:0] mask;
    } bank_t;

    bank_t         q, d;
    logic [DW-1:0] set_v;
    logic [DW-1:0] clr_v;
    logic [DW-1:0] pend_v;

    always_comb begin
        d     = q;
        set_v = evt_i & VALID;
        clr_v = wr_stat_i ? (wdata_i & VALID) : '0;
        // a set in the same cycle overrides a clear
        d.status = ((q.status & ~clr_v) | set_v) & VALID;
        if (wr_mask_i) begin
            d.mask = wdata_i & VALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.status <= '0;
            q.mask   <= MASK_RST & VALID;
        end else begin
            q <= d;
        end
    end

    // one pending flag per bit, reduced to the interrupt
    for (genvar b = 0; b < DW; b++) begin : g_pend
        assign pend_v[b] = q.status[b] & ~q.mask[b];
    end

    assign status_o = q.status;
    assign mask_o   = q.mask;
    assign irq_o    = |pend_v;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~VALID) == '0) && ((mask_o & ~VALID) == '0));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_i && ((evt_i & wdata_i) == '0)) |=> ((status_o & $past(wdata_i)) == '0));

    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & VALID)) |=> ((status_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));

    assert_rise_needs_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/errs_first_ptr.sv
module errs_first_ptr #(
    parameter int DW = 32,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] evt_i,
    output logic [PW-1:0] ptr_o
);
    logic [PW-1:0] ptr_q, ptr_d;
    logic [DW-1:0] hit;
    logic [PW-1:0] sel;

    always_comb begin
        hit = evt_i & ~mask_i;
        sel = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (hit[i]) sel = PW'(i);
        end
        ptr_d = ptr_q;
        if ((status_i == '0) && (hit != '0)) begin
            ptr_d = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i != '0) |=> $stable(ptr_o));

    assert_ptr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & ~mask_i) == '0) |=> $stable(ptr_o));
endmodule

// File: rtl/errs_regs.sv
module errs_regs #(
    parameter logic [errs_pkg::DW-1:0] UNC_VALID = 32'h0001_CFFF,
    parameter logic [errs_pkg::DW-1:0] COR_VALID = 32'h0000_007F,
    parameter logic [errs_pkg::DW-1:0] CAP_RST   = 32'h0000_0200,
    parameter int                      PW        = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [errs_pkg::AW-1:0]   req_addr,
    input  logic [errs_pkg::DW-1:0]   req_wdata,
    output logic                      rd_valid,
    output logic [errs_pkg::DW-1:0]   rd_data,
    input  logic [errs_pkg::DW-1:0]   unc_evt,
    input  logic [errs_pkg::DW-1:0]   cor_evt,
    output logic                      unc_irq,
    output logic                      cor_irq
);
    import errs_pkg::*;

    localparam logic [DW-1:0] PTR_FIELD = DW'((64'd1 << PW) - 64'd1);
    localparam logic [DW-1:0] CAP_FIXED = CAP_RST & ~PTR_FIELD;

    top_state_t    q, d;
    logic          aligned;
    logic [IW-1:0] widx;
    logic          wr_ok, rd_ok;
    logic [DW-1:0] unc_stat, unc_mask, cor_stat, cor_mask;
    logic [PW-1:0] first_ptr;
    logic [DW-1:0] cap_word;
    logic [DW-1:0] rd_mux;

    assign aligned = (req_addr[1:0] == 2'b00);
    assign widx    = req_addr[AW-1:2];
    assign wr_ok   = req_valid &  req_write & aligned;
    assign rd_ok   = req_valid & ~req_write;

    errs_status_bank #(.DW(DW), .VALID(UNC_VALID), .MASK_RST(UNC_VALID)) i_unc_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (unc_evt),
        .wr_stat_i (wr_ok && widx == W_UNC_STAT),
        .wr_mask_i (wr_ok && widx == W_UNC_MASK),
        .wdata_i   (req_wdata),
        .status_o  (unc_stat),
        .mask_o    (unc_mask),
        .irq_o     (unc_irq)
    );

    errs_status_bank #(.DW(DW), .VALID(COR_VALID), .MASK_RST(COR_VALID)) i_cor_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (cor_evt),
        .wr_stat_i (wr_ok && widx == W_COR_STAT),
        .wr_mask_i (wr_ok && widx == W_COR_MASK),
        .wdata_i   (req_wdata),
        .status_o  (cor_stat),
        .mask_o    (cor_mask),
        .irq_o     (cor_irq)
    );

    errs_first_ptr #(.DW(DW), .PW(PW)) i_first_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (unc_stat),
        .mask_i   (unc_mask),
        .evt_i    (unc_evt & UNC_VALID),
        .ptr_o    (first_ptr)
    );

    assign cap_word = CAP_FIXED | DW'(first_ptr);

    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (widx)
                W_UNC_STAT: rd_mux = unc_stat;
                W_UNC_MASK: rd_mux = unc_mask;
                W_UNC_SEV:  rd_mux = q.sev;
                W_COR_STAT: rd_mux = cor_stat;
                W_COR_MASK: rd_mux = cor_mask;
                W_CAP:      rd_mux = cap_word;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        d          = q;
        d.rd_valid = rd_ok;
        d.rd_data  = rd_ok ? rd_mux : '0;
        if (wr_ok && widx == W_UNC_SEV) begin
            d.sev = req_wdata & UNC_VALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.rd_valid <= 1'b0;
            q.rd_data  <= '0;
            q.sev      <= UNC_VALID;
        end else begin
            q <= d;
        end
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;

    assert_rd_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_misaligned_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !aligned) |=> (rd_data == '0));

    assert_sev_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sev & ~UNC_VALID) == '0);
endmodule

// File: tb/test_errs_regs.sv
`timescale 1ns/1ps
module test_errs_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] unc_evt, cor_evt;
    logic        unc_irq, cor_irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    errs_regs i_errs_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .unc_evt(unc_evt), .cor_evt(cor_evt),
        .unc_irq(unc_irq), .cor_irq(cor_irq)
    );

    localparam logic [7:0] A_US = 8'h00, A_UM = 8'h04, A_UV = 8'h08;
    localparam logic [7:0] A_CS = 8'h0C, A_CM = 8'h10, A_CAP = 8'h14;

    // {addr, write data, expected readback}
    localparam logic [71:0] VEC [10] = '{
        {A_UM,  32'hFFFF_FFFF, 32'h0001_CFFF},  // R2 R3
        {A_UM,  32'h0000_3000, 32'h0000_0000},  // R2 reserved only
        {A_UV,  32'h0000_A5A5, 32'h0000_85A5},  // R3
        {A_UV,  32'h0001_2345, 32'h0001_0345},  // R3
        {A_CM,  32'hFFFF_FF80, 32'h0000_0000},  // R2
        {A_CM,  32'h0000_005A, 32'h0000_005A},  // R3
        {A_CAP, 32'hFFFF_FFFF, 32'h0000_0200},  // R7
        {A_US,  32'hFFFF_FFFF, 32'h0000_0000},  // R4
        {8'h18, 32'hDEAD_BEEF, 32'h0000_0000},  // R9
        {8'hFC, 32'hFFFF_FFFF, 32'h0000_0000}   // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic [31:0] ue, input logic [31:0] ce);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        unc_evt = ue; cor_evt = ce;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        unc_evt = '0; cor_evt = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        op(1'b1, a, wd, '0, '0);
    endtask

    task automatic pulse(input logic [31:0] ue, input logic [31:0] ce);
        unc_evt = ue; cor_evt = ce;
        @(negedge clk);
        unc_evt = '0; cor_evt = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        check(req, rd_data, exp);
        req_valid = 1'b0; req_addr = '0;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; unc_evt = '0; cor_evt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_valid idle", {31'b0, rd_valid}, 32'h0);
        check("R1 irqs", {30'b0, unc_irq, cor_irq}, 32'h0);
        rd_chk("R1 unc status", A_US, 32'h0);
        rd_chk("R1 unc mask", A_UM, 32'h0001_CFFF);
        rd_chk("R1 unc severity", A_UV, 32'h0001_CFFF);
        rd_chk("R1 cor status", A_CS, 32'h0);
        rd_chk("R1 cor mask", A_CM, 32'h7F);
        rd_chk("R1 cap word", A_CAP, 32'h200);

        // table walk: write then read back
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd_chk("R2/R3/R7/R9 table", VEC[i][71:64], VEC[i][31:0]);
        end

        // R9 read timing
        req_valid = 1'b1; req_write = 1'b0; req_addr = A_CM;
        @(negedge clk);
        check("R9 rd_valid after read", {31'b0, rd_valid}, 32'h1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 rd_valid drops", {31'b0, rd_valid}, 32'h0);

        // unc mask is 0 now: events at bits 3, 12 (reserved), 14
        pulse(32'h0000_5008, '0);
        check("R6 unc_irq set", {31'b0, unc_irq}, 32'h1);
        rd_chk("R5 status set, reserved ignored", A_US, 32'h0000_4008);
        rd_chk("R8 first pointer lowest", A_CAP, 32'h0000_0203);
        pulse(32'h1, '0);
        rd_chk("R5 second event", A_US, 32'h0000_4009);
        rd_chk("R8 pointer holds", A_CAP, 32'h0000_0203);

        wr(A_US, 32'h8);
        rd_chk("R4 W1C clear bit3", A_US, 32'h0000_4001);
        wr(A_US, 32'h0);
        rd_chk("R4 write zero keeps", A_US, 32'h0000_4001);

        wr(A_UM, 32'h0001_CFFF);
        check("R6 masked irq low", {31'b0, unc_irq}, 32'h0);
        wr(A_UM, 32'h0);
        check("R6 unmasked irq high", {31'b0, unc_irq}, 32'h1);

        op(1'b1, A_US, 32'h0000_4001, 32'h1, '0);
        rd_chk("R5 set beats clear", A_US, 32'h0000_0001);
        wr(A_US, 32'h1);
        check("R6 irq low when clear", {31'b0, unc_irq}, 32'h0);

        wr(A_UM, 32'h1);
        pulse(32'h21, '0);
        rd_chk("R5 masked still recorded", A_US, 32'h21);
        rd_chk("R8 pointer skips masked", A_CAP, 32'h0000_0205);
        check("R6 irq on unmasked bit", {31'b0, unc_irq}, 32'h1);

        // correctable class
        wr(A_CM, 32'h0);
        pulse('0, 32'h0000_0204);
        check("R6 cor_irq set", {31'b0, cor_irq}, 32'h1);
        rd_chk("R5 cor status", A_CS, 32'h4);
        wr(A_CS, 32'hFF);
        check("R4 cor clear irq", {31'b0, cor_irq}, 32'h0);
        rd_chk("R4 cor status cleared", A_CS, 32'h0);

        // misaligned accesses
        wr(8'h05, 32'h0001_CFFF);
        rd_chk("R9 misaligned write ignored", A_UM, 32'h1);
        rd_chk("R9 misaligned read zero", 8'h06, 32'h0);
        rd_chk("R9 misaligned read zero status", 8'h01, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule